// File: doc/BRIEF.md
# Matrix Keypad Scan Controller

This block scans a key matrix of up to 16 row lines and 8 column lines. It drives one row low at a time, holds it for a fixed dwell, and samples the pulled-up column lines. Software sets the dwell through a debounce count. A key counts as down or up only after two consecutive frames read it the same way. At the end of each frame the block walks the settled matrix in row-major order and builds a snapshot of up to eight one-byte key entries. It queues the snapshot in a small FIFO when the settled key set has changed, or when a programmable repeat interval has elapsed while keys are held.

Software reaches the block through a plain 32-bit register port. Register reads are combinational, and a read strobe marks the read that has a side effect. There are two interrupt sources. The FIFO-count source fires when a queued snapshot brings the count up to a programmed threshold. The keypress source fires when a settled pressed key lies in a row whose wake mask is clear. Each source has a sticky status bit and its own enable. Snapshots flow from the scanner into the FIFO with no back-pressure: a snapshot that meets a full FIFO is dropped, and scanning never stalls. Software drains the FIFO at its own pace.

Top module: `kpd_scan_ctrl`

## Requirements
- R1: After reset all row lines are high, irq is low, and the control register (0x00) and the status register (0x04) read zero.
- R2: While the scanner is enabled (control bit 0), at most one row line is low at any time, and the rows are stepped in ascending order.
- R3: Each entry byte has a valid flag in bit 7, the row in bits 6:3 and the column in bits 2:0. Entries appear in row-major ascending order, with entry 0 in byte 0 of the low entry word (0x08) and entries 4 to 7 in the high entry word (0x0C). Unused bytes are zero, and keys beyond the eighth are left out.
- R4: A key state is accepted only after two consecutive frames agree. A snapshot is queued only when the accepted key set differs from the last one queued; a release to no keys queues an all-zero snapshot.
- R5: Status bits 7:4 give the number of queued snapshots. A read of 0x0C removes the oldest snapshot; a read of 0x0C with nothing queued changes nothing.
- R6: When the FIFO holds FIFO_DEPTH snapshots, newer snapshots are dropped and the count stays at FIFO_DEPTH.
- R7: Status bit 2 sets when a queued snapshot brings the count to at least the threshold in control bits 17:14 (threshold 0 disables it); writing 1 to bit 2 clears it.
- R8: Status bit 0 sets at the end of a frame that holds an accepted pressed key in an unmasked row. Bit 0 of the row's mask register at 0x40 + 4*row masks that row. Writing 1 to status bit 0 clears it.
- R9: irq is high while status bit 0 is set with control bit 1, or status bit 2 is set with control bit 3. Changing control bit 3 while scanning does not disturb queued snapshots.
- R10: With a nonzero frame count N in the repeat register (0x10), a held and unchanged key set is queued again every N frames.
- R11: Each row stays low for 16 plus the debounce count (control bits 13:4) clock cycles.
- R12: Clearing control bit 0 stops scanning and returns every row line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| row_drive_n | output | NUM_ROWS | Row lines, active low |
| col_sense_n | input | NUM_COLS | Column lines, pulled up, low means pressed |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle the assertions check the row-line discipline (one row low at most, all rows high when disabled). They also check the FIFO count arithmetic on pops, idle reads and saturation, and that irq falls only after a register write. Only the bench scenarios can show the content and ordering of snapshot entries, the two-frame acceptance and change-only queueing, the truncation to eight keys, the row masking of the wake source, the threshold interrupt, the repeat interval and the dwell length, because each depends on a modelled key matrix and on sequences that span many frames.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int ENT_PER_SNAP = 8;
  localparam int ENT_BITS     = 8;
  localparam int SNAP_BITS    = ENT_PER_SNAP * ENT_BITS;
  localparam int ROW_FLD      = 4;
  localparam int COL_FLD      = 3;
  localparam int BASE_DWELL   = 16;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_STAT   = 8'h04;
  localparam logic [7:0] A_ENT_LO = 8'h08;
  localparam logic [7:0] A_ENT_HI = 8'h0C;
  localparam logic [7:0] A_RPT    = 8'h10;

  localparam int C_EN    = 0;
  localparam int C_KPIE  = 1;
  localparam int C_FCIE  = 3;
  localparam int C_DB    = 4;
  localparam int C_THR   = 14;
  localparam int S_KP    = 0;
  localparam int S_FC    = 2;

  typedef struct packed {
    logic               valid;
    logic [ROW_FLD-1:0] row;
    logic [COL_FLD-1:0] col;
  } key_ent_t;
endpackage

// File: rtl/kpd_row_scanner.sv
module kpd_row_scanner #(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 8,
  parameter int DB_W     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                hold,
  input  logic [DB_W-1:0]     db_cnt,
  input  logic [NUM_COLS-1:0] col_sense_n,
  output logic [NUM_ROWS-1:0] row_drive_n,
  output logic                smp_valid,
  output logic [((NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1)-1:0] smp_row,
  output logic [NUM_COLS-1:0] smp_cols,
  output logic                smp_last
);
  localparam int ROW_IW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int CNT_W  = DB_W + 2;

  logic [NUM_COLS-1:0] col_s1, col_s2;
  logic [ROW_IW-1:0]   row_idx;
  logic [CNT_W-1:0]    dwell_cnt;
  logic [CNT_W-1:0]    dwell_m1;
  logic                at_last_row;

  assign dwell_m1    = CNT_W'(kpd_pkg::BASE_DWELL - 1) + CNT_W'(db_cnt);
  assign at_last_row = (row_idx == ROW_IW'(NUM_ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_s1 <= '1;
      col_s2 <= '1;
    end else begin
      col_s1 <= col_sense_n;
      col_s2 <= col_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_idx   <= '0;
      dwell_cnt <= '0;
      smp_valid <= 1'b0;
      smp_row   <= '0;
      smp_cols  <= '0;
      smp_last  <= 1'b0;
    end else if (!en) begin
      row_idx   <= '0;
      dwell_cnt <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (!hold) begin
        if (dwell_cnt == dwell_m1) begin
          dwell_cnt <= '0;
          smp_valid <= 1'b1;
          smp_row   <= row_idx;
          smp_cols  <= ~col_s2;
          smp_last  <= at_last_row;
          row_idx   <= at_last_row ? '0 : row_idx + 1'b1;
        end else begin
          dwell_cnt <= dwell_cnt + 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_drive_n[r] = !(en && !hold && (row_idx == ROW_IW'(r)));
  end
endmodule

// File: rtl/kpd_snap_builder.sv
module kpd_snap_builder
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 8,
  parameter int RPT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 smp_valid,
  input  logic [((NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1)-1:0] smp_row,
  input  logic [NUM_COLS-1:0]  smp_cols,
  input  logic                 smp_last,
  input  logic [NUM_ROWS-1:0]  wake_mask,
  input  logic [RPT_W-1:0]     rpt_frames,
  output logic                 busy,
  output logic                 snap_valid,
  output logic [SNAP_BITS-1:0] snap_data,
  output logic                 wake_evt
);
  localparam int ROW_IW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int COL_IW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int NENT_W = $clog2(ENT_PER_SNAP + 1);

  typedef enum logic [1:0] {B_COLLECT, B_WALK, B_DECIDE} bstate_t;

  bstate_t                              state;
  logic [NUM_ROWS-1:0][NUM_COLS-1:0]    raw_prev, deb, last_rep;
  logic [ROW_IW-1:0]                    walk_row;
  logic [COL_IW-1:0]                    walk_col;
  key_ent_t [ENT_PER_SNAP-1:0]          ents;
  logic [NENT_W-1:0]                    nent;
  logic                                 wake_acc;
  logic [RPT_W-1:0]                     rpt_cnt;
  logic [NUM_COLS-1:0]                  agree;
  logic                                 rpt_hit;

  assign agree     = ~(smp_cols ^ raw_prev[smp_row]);
  assign rpt_hit   = ({1'b0, rpt_cnt} + 1'b1) >= {1'b0, rpt_frames};
  assign busy      = (state != B_COLLECT) || (smp_valid && smp_last);
  assign snap_data = ents;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= B_COLLECT;
      raw_prev   <= '0;
      deb        <= '0;
      last_rep   <= '0;
      walk_row   <= '0;
      walk_col   <= '0;
      ents       <= '0;
      nent       <= '0;
      wake_acc   <= 1'b0;
      rpt_cnt    <= '0;
      snap_valid <= 1'b0;
      wake_evt   <= 1'b0;
    end else begin
      snap_valid <= 1'b0;
      wake_evt   <= 1'b0;
      if (!en) begin
        state    <= B_COLLECT;
        raw_prev <= '0;
        deb      <= '0;
        last_rep <= '0;
        rpt_cnt  <= '0;
      end else begin
        unique case (state)
          B_COLLECT: begin
            if (smp_valid) begin
              raw_prev[smp_row] <= smp_cols;
              deb[smp_row]      <= (deb[smp_row] & ~agree) | (smp_cols & agree);
              if (smp_last) begin
                state    <= B_WALK;
                walk_row <= '0;
                walk_col <= '0;
                ents     <= '0;
                nent     <= '0;
                wake_acc <= 1'b0;
              end
            end
          end
          B_WALK: begin
            if (deb[walk_row][walk_col]) begin
              if (nent < NENT_W'(ENT_PER_SNAP)) begin
                ents[nent[NENT_W-2:0]] <= '{valid: 1'b1,
                                            row:   ROW_FLD'(walk_row),
                                            col:   COL_FLD'(walk_col)};
                nent <= nent + 1'b1;
              end
              if (!wake_mask[walk_row]) wake_acc <= 1'b1;
            end
            if (walk_col == COL_IW'(NUM_COLS - 1)) begin
              walk_col <= '0;
              if (walk_row == ROW_IW'(NUM_ROWS - 1)) state <= B_DECIDE;
              else walk_row <= walk_row + 1'b1;
            end else begin
              walk_col <= walk_col + 1'b1;
            end
          end
          B_DECIDE: begin
            state    <= B_COLLECT;
            wake_evt <= wake_acc;
            if (deb != last_rep) begin
              snap_valid <= 1'b1;
              last_rep   <= deb;
              rpt_cnt    <= '0;
            end else if ((deb != '0) && (rpt_frames != '0)) begin
              if (rpt_hit) begin
                snap_valid <= 1'b1;
                rpt_cnt    <= '0;
              end else begin
                rpt_cnt <= rpt_cnt + 1'b1;
              end
            end else begin
              rpt_cnt <= '0;
            end
          end
          default: state <= B_COLLECT;
        endcase
      end
    end
  end
endmodule

// File: rtl/kpd_snap_fifo.sv
module kpd_snap_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push,
  input  logic [WIDTH-1:0]                push_data,
  input  logic                            pop,
  output logic [WIDTH-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]      count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/kpd_scan_ctrl.sv
module kpd_scan_ctrl
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int NUM_COLS   = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DB_W       = 10,
  parameter int THR_W      = 4,
  parameter int RPT_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [NUM_ROWS-1:0] row_drive_n,
  input  logic [NUM_COLS-1:0] col_sense_n,
  output logic                irq
);
  localparam int ROW_IW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  logic               ctl_en, ctl_kpie, ctl_fcie;
  logic [DB_W-1:0]    ctl_db;
  logic [THR_W-1:0]   ctl_thr;
  logic [RPT_W-1:0]   rpt_frames;
  logic [NUM_ROWS-1:0] wake_mask;
  logic               st_kp, st_fc;

  logic               hold, smp_valid, smp_last;
  logic [ROW_IW-1:0]  smp_row;
  logic [NUM_COLS-1:0] smp_cols;
  logic               snap_valid, wake_evt;
  logic [SNAP_BITS-1:0] snap_data, head;
  logic [CNT_W-1:0]   fifo_cnt;
  logic               push_ok, pop_ok;
  logic [CNT_W:0]     cnt_next;
  logic               fc_set;
  logic               is_mask;
  logic [3:0]         mask_idx;
  logic               wr_stat;

  kpd_row_scanner #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .DB_W(DB_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .hold(hold), .db_cnt(ctl_db),
    .col_sense_n(col_sense_n), .row_drive_n(row_drive_n),
    .smp_valid(smp_valid), .smp_row(smp_row), .smp_cols(smp_cols), .smp_last(smp_last)
  );

  kpd_snap_builder #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .RPT_W(RPT_W)) u_build (
    .clk(clk), .rst_n(rst_n), .en(ctl_en),
    .smp_valid(smp_valid), .smp_row(smp_row), .smp_cols(smp_cols), .smp_last(smp_last),
    .wake_mask(wake_mask), .rpt_frames(rpt_frames), .busy(hold),
    .snap_valid(snap_valid), .snap_data(snap_data), .wake_evt(wake_evt)
  );

  kpd_snap_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SNAP_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .push_data(snap_data),
    .pop(pop_ok), .head(head), .count(fifo_cnt)
  );

  assign push_ok  = snap_valid && (fifo_cnt < CNT_W'(FIFO_DEPTH));
  assign pop_ok   = reg_rd && (reg_addr == A_ENT_HI) && (fifo_cnt != '0);
  assign cnt_next = {1'b0, fifo_cnt} + (CNT_W+1)'(push_ok) - (CNT_W+1)'(pop_ok);
  assign fc_set   = push_ok && (ctl_thr != '0) &&
                    ({{(32-CNT_W-1){1'b0}}, cnt_next} >= {{(32-THR_W){1'b0}}, ctl_thr});
  assign mask_idx = reg_addr[5:2];
  assign is_mask  = (reg_addr[7:6] == 2'b01) && (reg_addr[1:0] == 2'b00) &&
                    (32'(mask_idx) < NUM_ROWS);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en     <= 1'b0;
      ctl_kpie   <= 1'b0;
      ctl_fcie   <= 1'b0;
      ctl_db     <= '0;
      ctl_thr    <= '0;
      rpt_frames <= '0;
      wake_mask  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        ctl_en   <= reg_wdata[C_EN];
        ctl_kpie <= reg_wdata[C_KPIE];
        ctl_fcie <= reg_wdata[C_FCIE];
        ctl_db   <= reg_wdata[C_DB +: DB_W];
        ctl_thr  <= reg_wdata[C_THR +: THR_W];
      end
      if (reg_addr == A_RPT) rpt_frames <= reg_wdata[RPT_W-1:0];
      if (is_mask) wake_mask[mask_idx[ROW_IW-1:0]] <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_kp <= 1'b0;
      st_fc <= 1'b0;
    end else begin
      st_kp <= wake_evt || (st_kp && !(wr_stat && reg_wdata[S_KP]));
      st_fc <= fc_set   || (st_fc && !(wr_stat && reg_wdata[S_FC]));
    end
  end

  assign irq = (st_kp && ctl_kpie) || (st_fc && ctl_fcie);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[C_EN]            = ctl_en;
      reg_rdata[C_KPIE]          = ctl_kpie;
      reg_rdata[C_FCIE]          = ctl_fcie;
      reg_rdata[C_DB +: DB_W]    = ctl_db;
      reg_rdata[C_THR +: THR_W]  = ctl_thr;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[7:4]  = 4'(fifo_cnt);
      reg_rdata[S_FC] = st_fc;
      reg_rdata[S_KP] = st_kp;
    end else if (reg_addr == A_ENT_LO) begin
      reg_rdata = (fifo_cnt != '0) ? head[31:0] : '0;
    end else if (reg_addr == A_ENT_HI) begin
      reg_rdata = (fifo_cnt != '0) ? head[63:32] : '0;
    end else if (reg_addr == A_RPT) begin
      reg_rdata[RPT_W-1:0] = rpt_frames;
    end else if (is_mask) begin
      reg_rdata[0] = wake_mask[mask_idx[ROW_IW-1:0]];
    end
  end
endmodule

// File: rtl/kpd_scan_checker.sv
module kpd_scan_checker #(
  parameter int NUM_ROWS = 16,
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [NUM_ROWS-1:0] row_drive_n,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [7:0]          reg_addr,
  input logic                irq,
  input logic [CNT_W-1:0]    fifo_cnt,
  input logic                snap_push
);
  logic rd_hi;
  assign rd_hi = reg_rd && (reg_addr == kpd_pkg::A_ENT_HI);

  AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_drive_n) <= 1); // R2

  AST_ROWS_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> &row_drive_n); // R12

  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && fifo_cnt != '0 && !snap_push) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1)); // R5

  AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && fifo_cnt == '0 && !snap_push) |=> (fifo_cnt == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(DEPTH) && !rd_hi) |=> (fifo_cnt == CNT_W'(DEPTH))); // R6

  AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr)); // R9
endmodule

bind kpd_scan_ctrl kpd_scan_checker #(
  .NUM_ROWS(NUM_ROWS), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .row_drive_n(row_drive_n),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .irq(irq),
  .fifo_cnt(fifo_cnt), .snap_push(push_ok)
);

// File: tb/tb_kpd_scan_ctrl.sv
module tb_kpd_scan_ctrl;
  localparam int NR = 16;
  localparam int NC = 8;
  localparam int DEPTH = 8;
  localparam int SETTLE = 2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NR-1:0] row_drive_n;
  logic [NC-1:0] col_sense_n;
  logic          irq;
  logic [NR-1:0][NC-1:0] keys = '0;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q[$];

  always #10 clk = ~clk;

  kpd_scan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .row_drive_n(row_drive_n),
    .col_sense_n(col_sense_n), .irq(irq)
  );

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      col_sense_n[c] = 1'b1;
      for (int r = 0; r < NR; r++)
        if (keys[r][c] && !row_drive_n[r]) col_sense_n[c] = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [63:0] calc_snap(input logic [NR-1:0][NC-1:0] k);
    logic [63:0] s = '0;
    int n = 0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (k[r][c] && n < 8) begin
          s[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    return s;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: change keys between frames and queue the expected snapshot.
  task automatic drive_keys(input logic [NR-1:0][NC-1:0] k, input bit expect_push);
    do @(negedge clk); while (!(&row_drive_n));
    keys = k;
    if (expect_push && exp_q.size() < DEPTH) exp_q.push_back(calc_snap(k));
    settle(SETTLE);
  endtask

  // Monitor: pop every queued snapshot and compare against the scoreboard.
  task automatic drain(input string req);
    logic [31:0] st, lo, hi;
    logic [63:0] e;
    int n;
    rd_reg(8'h04, st);
    n = int'(st[7:4]);
    chk(n == exp_q.size(), req, 64'(n), 64'(exp_q.size()));
    for (int i = 0; i < n; i++) begin
      rd_reg(8'h08, lo);
      rd_reg(8'h0C, hi);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 64'hX;
      chk({hi, lo} === e, req, {hi, lo}, e);
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [NR-1:0][NC-1:0] k;
    int bad, lowlen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(&row_drive_n, "R1 rows", 64'(row_drive_n), 64'hFFFF);
    chk(irq == 1'b0, "R1 irq", 64'(irq), 0);
    rd_reg(8'h00, d); chk(d == 0, "R1 ctrl", 64'(d), 0);
    rd_reg(8'h04, d); chk(d == 0, "R1 stat", 64'(d), 0);

    wr_reg(8'h00, 32'h1);
    // R2 at most one row low, rows stepped ascending
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($countones(~row_drive_n) > 1) bad++;
    end
    chk(bad == 0, "R2 one row low", 64'(bad), 0);

    // R3/R4 single key: row 2 col 5 -> byte 0x95
    k = '0; k[2][5] = 1'b1;
    do @(negedge clk); while (!(&row_drive_n));
    keys = k; exp_q.push_back(64'h95);
    settle(SETTLE);
    drain("R3 single key");

    // R4 no change -> nothing queued
    settle(SETTLE);
    drain("R4 unchanged");

    // R3 nine keys: first eight in row-major order
    k = '0;
    for (int c = 0; c < 7; c++) k[0][c] = 1'b1;
    k[1][0] = 1'b1; k[5][3] = 1'b1;
    drive_keys(k, 1'b1);
    drain("R3 truncation");

    // R4 release -> empty snapshot
    drive_keys('0, 1'b1);
    drain("R4 release");

    // R5 empty read does nothing
    rd_reg(8'h0C, d);
    chk(d == 0, "R5 empty entry", 64'(d), 0);
    rd_reg(8'h04, d);
    chk(d[7:4] == 0, "R5 empty count", 64'(d[7:4]), 0);

    // R8 wake masking of row 2
    wr_reg(8'h48, 32'h1);
    wr_reg(8'h04, 32'h5);
    wr_reg(8'h00, 32'h3);
    k = '0; k[2][1] = 1'b1;
    drive_keys(k, 1'b1);
    rd_reg(8'h04, d);
    chk(d[0] == 1'b0, "R8 masked row", 64'(d[0]), 0);
    chk(irq == 1'b0, "R9 irq masked", 64'(irq), 0);
    k[4][0] = 1'b1;
    drive_keys(k, 1'b1);
    rd_reg(8'h04, d);
    chk(d[0] == 1'b1, "R8 unmasked row", 64'(d[0]), 1);
    chk(irq == 1'b1, "R9 irq kp", 64'(irq), 1);
    drive_keys('0, 1'b1);
    wr_reg(8'h04, 32'h1);
    rd_reg(8'h04, d);
    chk(d[0] == 1'b0, "R8 w1c", 64'(d[0]), 0);
    chk(irq == 1'b0, "R9 irq cleared", 64'(irq), 0);
    drain("R8 snapshots");
    wr_reg(8'h48, 32'h0);

    // R7 threshold 2 with FIFO-count interrupt enabled
    wr_reg(8'h04, 32'h5);
    wr_reg(8'h00, (32'd2 << 14) | 32'h9);
    k = '0; k[9][6] = 1'b1;
    drive_keys(k, 1'b1);
    rd_reg(8'h04, d);
    chk(d[2] == 1'b0, "R7 below thr", 64'(d[2]), 0);
    drive_keys('0, 1'b1);
    rd_reg(8'h04, d);
    chk(d[2] == 1'b1, "R7 at thr", 64'(d[2]), 1);
    chk(irq == 1'b1, "R9 irq fc", 64'(irq), 1);
    wr_reg(8'h04, 32'h4);
    rd_reg(8'h04, d);
    chk(d[2] == 1'b0, "R7 w1c", 64'(d[2]), 0);
    chk(irq == 1'b0, "R9 irq fc cleared", 64'(irq), 0);
    drain("R7 snapshots");

    // R9 toggling FIFO-count enable while scanning keeps snapshots
    wr_reg(8'h00, 32'h1);
    k = '0; k[15][7] = 1'b1;
    drive_keys(k, 1'b1);
    wr_reg(8'h00, 32'h9);
    drain("R9 fcie toggle");
    drive_keys('0, 1'b1);
    drain("R9 release");
    wr_reg(8'h00, 32'h1);

    // R6 overflow: ten changes, only DEPTH kept
    for (int i = 0; i < 10; i++) begin
      k = '0; k[7][7] = (i % 2 == 0);
      drive_keys(k, 1'b1);
    end
    rd_reg(8'h04, d);
    chk(d[7:4] == DEPTH, "R6 saturate", 64'(d[7:4]), DEPTH);
    drain("R6 overflow");

    // R10 repeat every 3 frames while held
    wr_reg(8'h10, 32'd3);
    k = '0; k[3][3] = 1'b1;
    drive_keys(k, 1'b0);
    settle(SETTLE);
    wr_reg(8'h10, 32'd0);
    settle(500);
    begin
      logic [31:0] lo, hi;
      int n;
      rd_reg(8'h04, d);
      n = int'(d[7:4]);
      chk(n >= 3, "R10 repeat count", 64'(n), 3);
      for (int i = 0; i < n; i++) begin
        rd_reg(8'h08, lo);
        rd_reg(8'h0C, hi);
        chk({hi, lo} == calc_snap(k), "R10 repeat data", {hi, lo}, calc_snap(k));
      end
    end
    drive_keys('0, 1'b1);
    drain("R10 release");

    // R11 dwell = 16 + debounce count
    wr_reg(8'h00, (32'd5 << 4) | 32'h1);
    do @(negedge clk); while (row_drive_n[0] == 1'b0);
    do @(negedge clk); while (row_drive_n[0] == 1'b1);
    lowlen = 0;
    while (row_drive_n[0] == 1'b0) begin
      lowlen++;
      @(negedge clk);
    end
    chk(lowlen == 21, "R11 dwell", 64'(lowlen), 21);

    // R12 disable returns rows high
    wr_reg(8'h00, 32'h0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!(&row_drive_n)) bad++;
    end
    chk(bad == 0, "R12 disabled rows", 64'(bad), 0);

    summary();
  end
endmodule